// File: doc/BRIEF.md
# Asymmetric-Width Dual-Port RAM

This block is a synchronous dual-port RAM whose two ports see the same storage at different widths. The wide port reads and writes 32-bit words. The narrow port reads and writes single bytes. The storage is four byte-wide dual-port banks placed side by side. The wide port drives all four banks with one address. The narrow port takes its two lowest address bits as a lane number and the remaining bits as the word address.

On the narrow side, the lane number turns the byte write strobe into a single bank write enable. A read fetches all four banks at once. A registered lane number then steers the right byte to the output. Both ports are read-first and have one clock of read latency. Each port has its own enable. When a port is disabled it leaves the storage untouched and its read data does not change.

The parameter `SHARED_CLK` picks how the ports are clocked. With the default value of 1, one process on `clk_a` serves both ports, and `clk_b` must carry the same clock. With a value of 0, each port has its own clock domain.

Top module: `asym_dpram`

## Requirements
- R1: When `en_a` and `we_a` are high at a rising edge, all 32 bits of `wdata_a` are stored at word `addr_a`. A later wide read of that word returns them on `rdata_a` one clock after the read edge.
- R2: A narrow write (`en_b` and `we_b` high) changes only byte lane `addr_b[1:0]` of word `addr_b[AW_B-1:2]`. The other three bytes of that word keep their values.
- R3: Lane mapping: narrow address 4*w+k holds bits [8k+7:8k] of wide word w. Lane 0 is the least significant byte and lane 3 is the most significant.
- R4: A narrow read (`en_b` high, `we_b` low) returns the byte at `addr_b` on `rdata_b` one clock after the read edge, for every lane.
- R5: During a wide write, `rdata_a` returns the word stored before that write (read-first).
- R6: During a narrow write, `rdata_b` returns the byte stored before that write (read-first).
- R7: While a port's enable is low, its write enable, address and data have no effect. The storage stays unchanged and that port's read data holds its last value.
- R8: The highest word on the wide port and the highest byte address on the narrow port are reachable for both reads and writes.
- R9: In the same clock edge, a wide access and a narrow access to different locations both take effect. This holds for two writes and also for two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Wide-port clock (clocks both ports when SHARED_CLK=1) |
| en_a | input | 1 | Wide-port enable |
| we_a | input | 1 | Wide-port write enable |
| addr_a | input | clog2(DEPTH) | Wide-port word address |
| wdata_a | input | 32 | Wide-port write word |
| rdata_a | output | 32 | Wide-port read word, one clock latency |
| clk_b | input | 1 | Narrow-port clock |
| en_b | input | 1 | Narrow-port enable |
| we_b | input | 1 | Narrow-port write enable |
| addr_b | input | clog2(DEPTH)+2 | Narrow-port byte address; bits [1:0] select the lane |
| wdata_b | input | 8 | Narrow-port write byte |
| rdata_b | output | 8 | Narrow-port read byte, one clock latency |

## Verification
The assertions check the narrow-side decode on every cycle: at most one bank strobe is active, and it is the lane the address names. They also check on every cycle that the narrow output equals the bank byte chosen by the lane of the previous read, and that each port's read data holds while that port is disabled. Lane mapping, read-first data, byte isolation within a word, the top addresses and concurrent traffic on both ports involve stored contents. Only the bench scenarios can show these, by comparing against a byte-array model.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;
   localparam int LANES     = 4;
   localparam int LANE_W    = 8;
   localparam int LANE_BITS = $clog2(LANES);
   localparam int WORD_W    = LANES * LANE_W;

   typedef logic [LANES-1:0][LANE_W-1:0] lane_vec_t;
   typedef logic [LANE_BITS-1:0]         lane_idx_t;
endpackage

// File: rtl/asym_ram_bank.sv
// One byte-wide true dual-port bank, read-first on both ports.
module asym_ram_bank #(
   parameter int DEPTH      = 64,
   parameter int DW         = 8,
   parameter int AW         = $clog2(DEPTH),
   parameter bit SHARED_CLK = 1'b1
) (
   input  logic          clk_a,
   input  logic          en_a,
   input  logic          we_a,
   input  logic [AW-1:0] addr_a,
   input  logic [DW-1:0] din_a,
   output logic [DW-1:0] dout_a,
   input  logic          clk_b,
   input  logic          en_b,
   input  logic          we_b,
   input  logic [AW-1:0] addr_b,
   input  logic [DW-1:0] din_b,
   output logic [DW-1:0] dout_b
);
   logic [DW-1:0] mem [DEPTH];

   generate
      if (SHARED_CLK) begin : g_one_clock
         always_ff @(posedge clk_a) begin
            if (en_a) begin
               dout_a <= mem[addr_a];
               if (we_a) mem[addr_a] <= din_a;
            end
            if (en_b) begin
               dout_b <= mem[addr_b];
               if (we_b) mem[addr_b] <= din_b;
            end
         end
      end else begin : g_two_clocks
         always_ff @(posedge clk_a) begin
            if (en_a) begin
               dout_a <= mem[addr_a];
               if (we_a) mem[addr_a] <= din_a;
            end
         end
         always_ff @(posedge clk_b) begin
            if (en_b) begin
               dout_b <= mem[addr_b];
               if (we_b) mem[addr_b] <= din_b;
            end
         end
      end
   endgenerate

   // Arming counters: the checks below start after two edges.
   logic [1:0] arm_a = 2'd0;
   logic [1:0] arm_b = 2'd0;
   always_ff @(posedge clk_a) if (arm_a != 2'd2) arm_a <= arm_a + 2'd1;
   always_ff @(posedge clk_b) if (arm_b != 2'd2) arm_b <= arm_b + 2'd1;

   // R7: a disabled port keeps its read data
   a_r7_hold_a: assert property (@(posedge clk_a) disable iff (arm_a != 2'd2)
      !en_a |=> $stable(dout_a));
   a_r7_hold_b: assert property (@(posedge clk_b) disable iff (arm_b != 2'd2)
      !en_b |=> $stable(dout_b));
endmodule

// File: rtl/asym_ram_lane_dec.sv
// Turns the narrow write strobe into one bank write enable per lane.
module asym_ram_lane_dec
   import asym_ram_pkg::*;
(
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  lane_idx_t        lane,
   output logic [LANES-1:0] we_lane
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign we_lane[i] = en & we & (lane == lane_idx_t'(i));
   end

   logic [1:0] arm = 2'd0;
   always_ff @(posedge clk) if (arm != 2'd2) arm <= arm + 2'd1;

   // R2: never more than one bank strobe
   a_r2_onehot_we: assert property (@(posedge clk) disable iff (arm != 2'd2)
      $onehot0(we_lane));
   // R2: a narrow write raises exactly the addressed lane
   a_r2_lane_match: assert property (@(posedge clk) disable iff (arm != 2'd2)
      (en && we) |-> (we_lane[lane] && $countones(we_lane) == 1));
endmodule

// File: rtl/asym_ram_byte_sel.sv
// Registers the lane of a narrow read and steers that bank's byte out.
module asym_ram_byte_sel
   import asym_ram_pkg::*;
(
   input  logic              clk,
   input  logic              en,
   input  lane_idx_t         lane,
   input  lane_vec_t         lanes_q,
   output logic [LANE_W-1:0] dout
);
   lane_idx_t sel_q;

   always_ff @(posedge clk) begin
      if (en) sel_q <= lane;
   end

   assign dout = lanes_q[sel_q];

   logic [1:0] arm = 2'd0;
   logic       en_d = 1'b0;
   lane_idx_t  lane_d;
   always_ff @(posedge clk) begin
      if (arm != 2'd2) arm <= arm + 2'd1;
      en_d   <= en;
      lane_d <= lane;
   end

   // R4: after a read edge the output carries the addressed bank's byte
   a_r4_byte_route: assert property (@(posedge clk) disable iff (arm != 2'd2)
      en_d |-> (dout == lanes_q[lane_d]));
endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
   import asym_ram_pkg::*;
#(
   parameter int DEPTH      = 64,
   parameter bit SHARED_CLK = 1'b1,
   localparam int AW_A      = $clog2(DEPTH),
   localparam int AW_B      = AW_A + LANE_BITS
) (
   input  logic              clk_a,
   input  logic              en_a,
   input  logic              we_a,
   input  logic [AW_A-1:0]   addr_a,
   input  logic [WORD_W-1:0] wdata_a,
   output logic [WORD_W-1:0] rdata_a,
   input  logic              clk_b,
   input  logic              en_b,
   input  logic              we_b,
   input  logic [AW_B-1:0]   addr_b,
   input  logic [LANE_W-1:0] wdata_b,
   output logic [LANE_W-1:0] rdata_b
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("asym_dpram: DEPTH must be a power of two of at least 2");
   end
   if (LANES * LANE_W != WORD_W) begin : g_bad_lanes
      $error("asym_dpram: lane count and width disagree with word width");
   end

   lane_idx_t        lane_b;
   logic [AW_A-1:0]  word_b;
   logic [LANES-1:0] we_lane;
   lane_vec_t        a_q;
   lane_vec_t        b_q;

   assign lane_b = addr_b[LANE_BITS-1:0];
   assign word_b = addr_b[AW_B-1:LANE_BITS];

   asym_ram_lane_dec u_dec (
      .clk     (clk_b),
      .en      (en_b),
      .we      (we_b),
      .lane    (lane_b),
      .we_lane (we_lane)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_bank
      asym_ram_bank #(
         .DEPTH      (DEPTH),
         .DW         (LANE_W),
         .AW         (AW_A),
         .SHARED_CLK (SHARED_CLK)
      ) u_bank (
         .clk_a  (clk_a),
         .en_a   (en_a),
         .we_a   (we_a),
         .addr_a (addr_a),
         .din_a  (wdata_a[i*LANE_W +: LANE_W]),
         .dout_a (a_q[i]),
         .clk_b  (clk_b),
         .en_b   (en_b),
         .we_b   (we_lane[i]),
         .addr_b (word_b),
         .din_b  (wdata_b),
         .dout_b (b_q[i])
      );
   end

   assign rdata_a = a_q;

   asym_ram_byte_sel u_sel (
      .clk     (clk_b),
      .en      (en_b),
      .lane    (lane_b),
      .lanes_q (b_q),
      .dout    (rdata_b)
   );
endmodule

// File: tb/asym_dpram_test.sv
module asym_dpram_test;
   localparam int DEPTH = 64;
   localparam int AW_A  = $clog2(DEPTH);
   localparam int AW_B  = AW_A + 2;
   localparam int NB    = DEPTH * 4;

   logic            clk = 1'b0;
   logic            en_a = 1'b0, we_a = 1'b0;
   logic [AW_A-1:0] addr_a = '0;
   logic [31:0]     wdata_a = '0;
   logic [31:0]     rdata_a;
   logic            en_b = 1'b0, we_b = 1'b0;
   logic [AW_B-1:0] addr_b = '0;
   logic [7:0]      wdata_b = '0;
   logic [7:0]      rdata_b;

   logic [7:0] model [NB];
   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   asym_dpram #(.DEPTH(DEPTH)) uut (
      .clk_a(clk), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
      .wdata_a(wdata_a), .rdata_a(rdata_a),
      .clk_b(clk), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
      .wdata_b(wdata_b), .rdata_b(rdata_b)
   );

   function automatic logic [31:0] mword(input int w);
      return {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]};
   endfunction

   function automatic void mput(input int w, input logic [31:0] d);
      for (int k = 0; k < 4; k++) model[4*w+k] = d[8*k +: 8];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one cycle from a falling edge; return at the next falling edge.
   task automatic cyc(input logic ea, input logic wa, input int aa, input logic [31:0] da,
                      input logic eb, input logic wb, input int ab, input logic [7:0] db);
      en_a = ea; we_a = wa; addr_a = AW_A'(aa); wdata_a = da;
      en_b = eb; we_b = wb; addr_b = AW_B'(ab); wdata_b = db;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_a(input int w, input logic [31:0] d);
      cyc(1, 1, w, d, 0, 0, 0, 8'h00); mput(w, d);
   endtask
   task automatic rd_a(input int w);
      cyc(1, 0, w, 32'h0, 0, 0, 0, 8'h00);
   endtask
   task automatic wr_b(input int a, input logic [7:0] d);
      cyc(0, 0, 0, 32'h0, 1, 1, a, d); model[a] = d;
   endtask
   task automatic rd_b(input int a);
      cyc(0, 0, 0, 32'h0, 1, 0, a, 8'h00);
   endtask

   // R1, R3, R4: fill through the wide port, read back both ways
   task automatic t_word_fill();
      for (int w = 0; w < DEPTH; w++) wr_a(w, 32'h9E3779B9 * (w + 1));
      for (int w = 0; w < DEPTH; w += 7) begin
         rd_a(w); chk("R1", rdata_a, mword(w));
      end
      wr_a(5, 32'h44332211);
      for (int k = 0; k < 4; k++) begin
         rd_b(4*5 + k); chk("R3", {24'h0, rdata_b}, {24'h0, 8'h11 * (k + 1)});
      end
      for (int a = 0; a < NB; a++) begin
         rd_b(a); chk("R4", {24'h0, rdata_b}, {24'h0, model[a]});
      end
   endtask

   // R2, R3: byte writes on the narrow port, word reads on the wide port
   task automatic t_byte_write();
      for (int w = 8; w < 16; w++) begin
         int k = w % 4;
         wr_b(4*w + k, 8'hC0 + 8'(w));
         rd_a(w);
         chk("R2", rdata_a, mword(w));
         chk("R3", {24'h0, rdata_a[8*k +: 8]}, {24'h0, 8'hC0 + 8'(w)});
      end
   endtask

   // R5: wide write returns the old word
   task automatic t_read_first_a();
      logic [31:0] old = mword(7);
      wr_a(7, 32'hDEADBEEF);
      chk("R5", rdata_a, old);
      rd_a(7); chk("R5", rdata_a, 32'hDEADBEEF);
   endtask

   // R6: narrow write returns the old byte
   task automatic t_read_first_b();
      logic [7:0] old = model[4*9 + 2];
      wr_b(4*9 + 2, 8'h5A);
      chk("R6", {24'h0, rdata_b}, {24'h0, old});
      rd_b(4*9 + 2); chk("R6", {24'h0, rdata_b}, 32'h5A);
   endtask

   // R7: disabled ports neither write nor change their read data
   task automatic t_disabled();
      rd_a(3);
      rd_b(4*3 + 1);
      cyc(0, 1, 3, 32'h01020304, 0, 1, 4*3 + 1, 8'hEE);
      chk("R7", rdata_a, mword(3));
      chk("R7", {24'h0, rdata_b}, {24'h0, model[4*3 + 1]});
      cyc(0, 0, 4, 32'h0, 0, 0, 4*4 + 3, 8'h00);
      chk("R7", {24'h0, rdata_b}, {24'h0, model[4*3 + 1]});
      rd_a(3); chk("R7", rdata_a, mword(3));
   endtask

   // R8: top addresses on both ports
   task automatic t_edges();
      wr_a(DEPTH - 1, 32'hA1B2C3D4);
      rd_b(NB - 1); chk("R8", {24'h0, rdata_b}, 32'hA1);
      wr_b(NB - 4, 8'h77);
      rd_a(DEPTH - 1); chk("R8", rdata_a, 32'hA1B2C377);
      wr_b(0, 8'h3E);
      rd_a(0); chk("R8", rdata_a, mword(0));
   endtask

   // R9: both ports active in one edge at different locations
   task automatic t_parallel();
      cyc(1, 1, 10, 32'h0BADF00D, 1, 1, 4*20 + 2, 8'h99);
      mput(10, 32'h0BADF00D); model[4*20 + 2] = 8'h99;
      rd_a(10); chk("R9", rdata_a, 32'h0BADF00D);
      rd_a(20); chk("R9", rdata_a, mword(20));
      cyc(1, 0, 12, 32'h0, 1, 0, 4*13 + 1, 8'h00);
      chk("R9", rdata_a, mword(12));
      chk("R9", {24'h0, rdata_b}, {24'h0, model[4*13 + 1]});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_word_fill();
      t_byte_write();
      t_read_first_a();
      t_read_first_b();
      t_disabled();
      t_edges();
      t_parallel();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule